// File: doc/BRIEF.md
# Multi-Die Flash Ready Poller

This block answers one question for a serial NOR flash that stacks several dies behind one chip select: can the flash take a new command? On a start pulse it reads the volatile status byte of each die in turn, using an addressed register-read request. It then reports one of three results: ready, busy or error. All requests go to a generic flash command engine through a single request/response port. The block supplies the opcode, address byte count, address, dummy count, data length and write data. The engine returns read data, a transfer-error flag and a done pulse.

The dies are walked from index 0 upward. The walk stops at the first die that is still working. Any die whose status shows a failed program or erase triggers a recovery pair: a clear-flags command, then a write disable. The write disable is needed because the write-enable latch remains set after such a failure. The address of each die comes from a configuration vector of per-die volatile base offsets, together with a die count. A mode input switches the status read between the legacy single-rate form and the octal double-rate form. Configuration inputs must be held stable while a poll runs.

Top module: `nor_ready_poller`

## Requirements
- R1: Every status read is a request with opcode 0x65. Its address equals the base offset of the die being read (register index 0). With `octal_dtr_i` low it carries `mode_abytes_i` address bytes, zero dummy cycles and a data length of 1.
- R2: With `octal_dtr_i` high a status read carries `full_abytes_i` address bytes, `dtr_dummy_i` dummy cycles and a data length of 2. In both modes the status byte is taken from `rsp_rdata_i[7:0]`.
- R3: Dies are read in ascending index order starting at 0, one request per die. The next request is issued only after the `rsp_done_i` of the previous one.
- R4: If status bit 0 (write in progress) is set on die k, the result is busy. No die above k is read.
- R5: The result is ready only after every die from 0 to `die_cnt_i`-1 has returned a status with bits 0, 5 and 6 clear. Bits 1 to 4 and 7 are ignored. A die count of 0 reports ready without issuing any request.
- R6: If status bit 5 (erase failed) or bit 6 (program failed) is set, the block issues a clear command and then a write disable (opcode 0x04), and reports error. This check takes precedence over bit 0.
- R7: The clear opcode is 0x30 when `clr_sel_i` is 0 and 0x82 when it is 1. Clear and write-disable requests carry 0 address bytes, 0 dummy cycles and a data length of 0.
- R8: A done pulse that comes with `rsp_err_i` high ends the poll with error at once. No further request is issued, and no clear sequence is started after a failed status read.
- R9: At the end of a poll, `done_o` is high for exactly one cycle together with exactly one of `ready_o`, `busy_o` or `error_o`. All four are low at any other time, including after reset.
- R10: `start_i` is ignored while a poll is in progress.
- R11: `req_valid_o` is a one-cycle pulse for each request. A `rsp_done_i` that arrives while no request is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a poll (accepted when idle) |
| die_cnt_i | input | 3 | Number of dies to poll (0 to N_DIE) |
| die_base_i | input | 128 | Volatile register base offset per die, die 0 in the low bits |
| octal_dtr_i | input | 1 | Use the octal double-rate status read form |
| mode_abytes_i | input | 3 | Address byte count of the current address mode |
| full_abytes_i | input | 3 | Full address byte count used in octal double-rate mode |
| dtr_dummy_i | input | 5 | Dummy cycles for the octal double-rate status read |
| clr_sel_i | input | 1 | Clear opcode select: 0 gives 0x30, 1 gives 0x82 |
| req_valid_o | output | 1 | Request pulse to the command engine |
| req_opcode_o | output | 8 | Request opcode |
| req_abytes_o | output | 3 | Request address byte count |
| req_addr_o | output | 32 | Request address |
| req_dummy_o | output | 5 | Request dummy cycle count |
| req_len_o | output | 2 | Request data length in bytes |
| req_wdata_o | output | 16 | Request write data (always zero for these commands) |
| rsp_done_i | input | 1 | Engine completion pulse |
| rsp_err_i | input | 1 | Engine transfer error, qualified by rsp_done_i |
| rsp_rdata_i | input | 16 | Engine read data |
| done_o | output | 1 | Poll finished (one cycle) |
| ready_o | output | 1 | All dies ready |
| busy_o | output | 1 | A die is still busy |
| error_o | output | 1 | Program/erase failure or transfer error |

## Verification
A wrong die index shows up on the address of the very next status read. A stale or skipped index also changes the number of reads before `done_o`. Both are visible within one request of the fault. A wrong sequencer state shows in the opcode sequence within one request: a read after a clear, a write disable without a clear, or a missing recovery pair. A mis-decoded status bit gives the wrong result flag in the cycle after the final done pulse. Corrupted result registers break the one-of-three rule on the flags in the same cycle they are wrong.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

  localparam logic [7:0] OP_RD_ANY   = 8'h65;
  localparam logic [7:0] OP_CLR_SR   = 8'h30;
  localparam logic [7:0] OP_CLR_FAIL = 8'h82;
  localparam logic [7:0] OP_WR_DIS   = 8'h04;

  localparam int unsigned SB_WIP     = 0;
  localparam int unsigned SB_WEL     = 1;
  localparam int unsigned SB_ERS_ERR = 5;
  localparam int unsigned SB_PGM_ERR = 6;

  typedef enum logic [1:0] {CMD_NONE, CMD_STAT, CMD_CLR, CMD_WRDI} cmd_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_CLR_REQ, S_CLR_WAIT, S_WRDI_REQ, S_WRDI_WAIT
  } state_e;

  typedef enum logic [1:0] {RES_NONE, RES_READY, RES_BUSY, RES_ERR} res_e;

endpackage

// File: rtl/nor_poll_stat_dec.sv
module nor_poll_stat_dec
  import nor_poll_pkg::*;
(
  input  logic [7:0] stat_i,
  output logic       busy_o,
  output logic       fail_o
);
  assign busy_o = stat_i[SB_WIP];
  assign fail_o = stat_i[SB_ERS_ERR] | stat_i[SB_PGM_ERR];
endmodule

// File: rtl/nor_poll_cmd_build.sv
module nor_poll_cmd_build
  import nor_poll_pkg::*;
#(
  parameter int N_DIE   = 4,
  parameter int ADDR_W  = 32,
  parameter int DUMMY_W = 5,
  parameter int AB_W    = 3,
  parameter int LEN_W   = 2,
  parameter int IDX_W   = 2
) (
  input  cmd_e                      cmd_i,
  input  logic [IDX_W-1:0]          die_idx_i,
  input  logic [N_DIE*ADDR_W-1:0]   die_base_i,
  input  logic                      octal_dtr_i,
  input  logic [AB_W-1:0]           mode_abytes_i,
  input  logic [AB_W-1:0]           full_abytes_i,
  input  logic [DUMMY_W-1:0]        dtr_dummy_i,
  input  logic                      clr_sel_i,
  output logic [7:0]                opcode_o,
  output logic [AB_W-1:0]           abytes_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [DUMMY_W-1:0]        dummy_o,
  output logic [LEN_W-1:0]          len_o
);
  logic [ADDR_W-1:0] base_arr [N_DIE];

  for (genvar g = 0; g < N_DIE; g++) begin : g_base
    assign base_arr[g] = die_base_i[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    opcode_o = '0;
    abytes_o = '0;
    addr_o   = '0;
    dummy_o  = '0;
    len_o    = '0;
    unique case (cmd_i)
      CMD_STAT: begin
        opcode_o = OP_RD_ANY;
        addr_o   = base_arr[die_idx_i];  // status register sits at index 0
        if (octal_dtr_i) begin
          // 1-byte transfers are illegal in octal DTR: read 2, use byte 0
          abytes_o = full_abytes_i;
          dummy_o  = dtr_dummy_i;
          len_o    = LEN_W'(2);
        end else begin
          abytes_o = mode_abytes_i;
          len_o    = LEN_W'(1);
        end
      end
      CMD_CLR:  opcode_o = clr_sel_i ? OP_CLR_FAIL : OP_CLR_SR;
      CMD_WRDI: opcode_o = OP_WR_DIS;
      default:  ;
    endcase
  end
endmodule

// File: rtl/nor_ready_poller.sv
module nor_ready_poller
  import nor_poll_pkg::*;
#(
  parameter int N_DIE   = 4,
  parameter int ADDR_W  = 32,
  parameter int DUMMY_W = 5,
  parameter int AB_W    = 3,
  parameter int LEN_W   = 2,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = (N_DIE > 1) ? $clog2(N_DIE) : 1,
  localparam int CNT_W  = $clog2(N_DIE + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [CNT_W-1:0]        die_cnt_i,
  input  logic [N_DIE*ADDR_W-1:0] die_base_i,
  input  logic                    octal_dtr_i,
  input  logic [AB_W-1:0]         mode_abytes_i,
  input  logic [AB_W-1:0]         full_abytes_i,
  input  logic [DUMMY_W-1:0]      dtr_dummy_i,
  input  logic                    clr_sel_i,
  output logic                    req_valid_o,
  output logic [7:0]              req_opcode_o,
  output logic [AB_W-1:0]         req_abytes_o,
  output logic [ADDR_W-1:0]       req_addr_o,
  output logic [DUMMY_W-1:0]      req_dummy_o,
  output logic [LEN_W-1:0]        req_len_o,
  output logic [DATA_W-1:0]       req_wdata_o,
  input  logic                    rsp_done_i,
  input  logic                    rsp_err_i,
  input  logic [DATA_W-1:0]       rsp_rdata_i,
  output logic                    done_o,
  output logic                    ready_o,
  output logic                    busy_o,
  output logic                    error_o
);
  state_e           state_q, state_d;
  logic [IDX_W-1:0] die_idx_q, die_idx_d;
  res_e             res_d;
  cmd_e             cmd;
  logic             st_busy, st_fail, last_die;

  nor_poll_stat_dec u_dec (
    .stat_i (rsp_rdata_i[7:0]),
    .busy_o (st_busy),
    .fail_o (st_fail)
  );

  nor_poll_cmd_build #(
    .N_DIE(N_DIE), .ADDR_W(ADDR_W), .DUMMY_W(DUMMY_W),
    .AB_W(AB_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_cmd (
    .cmd_i         (cmd),
    .die_idx_i     (die_idx_q),
    .die_base_i    (die_base_i),
    .octal_dtr_i   (octal_dtr_i),
    .mode_abytes_i (mode_abytes_i),
    .full_abytes_i (full_abytes_i),
    .dtr_dummy_i   (dtr_dummy_i),
    .clr_sel_i     (clr_sel_i),
    .opcode_o      (req_opcode_o),
    .abytes_o      (req_abytes_o),
    .addr_o        (req_addr_o),
    .dummy_o       (req_dummy_o),
    .len_o         (req_len_o)
  );

  assign req_wdata_o = '0;
  assign req_valid_o = (state_q == S_RD_REQ) || (state_q == S_CLR_REQ) ||
                       (state_q == S_WRDI_REQ);
  assign last_die    = (CNT_W'(die_idx_q) + CNT_W'(1)) == die_cnt_i;

  always_comb begin
    unique case (state_q)
      S_RD_REQ,   S_RD_WAIT:   cmd = CMD_STAT;
      S_CLR_REQ,  S_CLR_WAIT:  cmd = CMD_CLR;
      S_WRDI_REQ, S_WRDI_WAIT: cmd = CMD_WRDI;
      default:                 cmd = CMD_NONE;
    endcase
  end

  always_comb begin
    state_d   = state_q;
    die_idx_d = die_idx_q;
    res_d     = RES_NONE;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        die_idx_d = '0;
        if (die_cnt_i == '0) res_d   = RES_READY;
        else                 state_d = S_RD_REQ;
      end
      S_RD_REQ:  state_d = S_RD_WAIT;
      S_RD_WAIT: if (rsp_done_i) begin
        if (rsp_err_i) begin
          res_d = RES_ERR; state_d = S_IDLE;
        end else if (st_fail) begin
          state_d = S_CLR_REQ;  // failure outranks write-in-progress
        end else if (st_busy) begin
          res_d = RES_BUSY; state_d = S_IDLE;
        end else if (last_die) begin
          res_d = RES_READY; state_d = S_IDLE;
        end else begin
          die_idx_d = die_idx_q + IDX_W'(1);
          state_d   = S_RD_REQ;
        end
      end
      S_CLR_REQ:  state_d = S_CLR_WAIT;
      S_CLR_WAIT: if (rsp_done_i) begin
        if (rsp_err_i) begin
          res_d = RES_ERR; state_d = S_IDLE;
        end else begin
          state_d = S_WRDI_REQ;
        end
      end
      S_WRDI_REQ:  state_d = S_WRDI_WAIT;
      S_WRDI_WAIT: if (rsp_done_i) begin
        res_d = RES_ERR; state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      die_idx_q <= '0;
      done_o    <= 1'b0;
      ready_o   <= 1'b0;
      busy_o    <= 1'b0;
      error_o   <= 1'b0;
    end else begin
      state_q   <= state_d;
      die_idx_q <= die_idx_d;
      done_o    <= res_d != RES_NONE;
      ready_o   <= res_d == RES_READY;
      busy_o    <= res_d == RES_BUSY;
      error_o   <= res_d == RES_ERR;
    end
  end

  // R9: one result flag with done, none without
  p_one_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({ready_o, busy_o, error_o}) == 1);
  p_no_flag_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(ready_o || busy_o || error_o));
  // R11: requests are single-cycle pulses
  p_req_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  // R2: octal status read shape follows the mode inputs
  p_octal_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_opcode_o == OP_RD_ANY && octal_dtr_i) |->
      (req_len_o == LEN_W'(2) && req_dummy_o == dtr_dummy_i &&
       req_abytes_o == full_abytes_i));
  // R5: ready from a read only once the last die was read
  p_ready_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(state_q) == S_RD_WAIT) |->
      (CNT_W'($past(die_idx_q)) + CNT_W'(1)) == die_cnt_i);
  // R4: nothing further is issued after busy unless a new poll starts
  p_busy_stops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> !req_valid_o);
endmodule

// File: tb/nor_ready_poller_tb_top.sv
`timescale 1ns/1ps
module nor_ready_poller_tb_top;
  localparam time CLK_P = 8ns;

  typedef struct packed {
    logic [2:0]  n;
    logic        oct;
    logic        clr;
    logic [31:0] st;      // {die3,die2,die1,die0}
    logic [2:0]  err_at;  // 1-based request number that returns rsp_err, 0 = none
    logic [1:0]  res;     // 1 ready, 2 busy, 3 error
    logic [2:0]  nrd;
    logic [7:0]  clr_op;  // 0 = no clear expected
    logic        wrdi;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 1'b0, 32'h00000000, 3'd0, 2'd1, 3'd1, 8'h00, 1'b0},
    '{3'd4, 1'b0, 1'b0, 32'h00000000, 3'd0, 2'd1, 3'd4, 8'h00, 1'b0},
    '{3'd4, 1'b0, 1'b0, 32'h00010000, 3'd0, 2'd2, 3'd3, 8'h00, 1'b0},
    '{3'd2, 1'b0, 1'b0, 32'h00000001, 3'd0, 2'd2, 3'd1, 8'h00, 1'b0},
    '{3'd3, 1'b0, 1'b0, 32'h00002000, 3'd0, 2'd3, 3'd2, 8'h30, 1'b1},
    '{3'd3, 1'b0, 1'b1, 32'h00004000, 3'd0, 2'd3, 3'd2, 8'h82, 1'b1},
    '{3'd2, 1'b0, 1'b0, 32'h00000021, 3'd0, 2'd3, 3'd1, 8'h30, 1'b1},
    '{3'd4, 1'b1, 1'b0, 32'h02020202, 3'd0, 2'd1, 3'd4, 8'h00, 1'b0},
    '{3'd3, 1'b1, 1'b0, 32'h00010000, 3'd0, 2'd2, 3'd3, 8'h00, 1'b0},
    '{3'd2, 1'b0, 1'b0, 32'h00000000, 3'd2, 2'd3, 3'd2, 8'h00, 1'b0},
    '{3'd1, 1'b0, 1'b1, 32'h00000040, 3'd2, 2'd3, 3'd1, 8'h82, 1'b0},
    '{3'd0, 1'b0, 1'b0, 32'h00000000, 3'd0, 2'd1, 3'd0, 8'h00, 1'b0},
    '{3'd4, 1'b0, 1'b0, 32'h9E000000, 3'd0, 2'd1, 3'd4, 8'h00, 1'b0},
    '{3'd2, 1'b1, 1'b1, 32'h00006000, 3'd0, 2'd3, 3'd2, 8'h82, 1'b1}
  };

  localparam logic [127:0] BASES = {32'h06800000, 32'h04800000, 32'h02800000, 32'h00800000};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, oct = 1'b0, clr_sel = 1'b0;
  logic [2:0] die_cnt = '0;
  logic rsp_done = 1'b0, rsp_err = 1'b0;
  logic [15:0] rsp_rdata = '0;
  logic req_valid, done, ready, busy, error;
  logic [7:0] req_op;
  logic [2:0] req_ab;
  logic [31:0] req_addr;
  logic [4:0] req_dummy;
  logic [1:0] req_len;
  logic [15:0] req_wdata;

  int checks = 0, errors = 0;
  bit finished = 0;
  int got_res, got_nrd, got_wrdi;
  logic [7:0] got_clr;

  always #(CLK_P/2) clk = ~clk;

  nor_ready_poller dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .die_cnt_i(die_cnt),
    .die_base_i(BASES), .octal_dtr_i(oct), .mode_abytes_i(3'd3),
    .full_abytes_i(3'd4), .dtr_dummy_i(5'd6), .clr_sel_i(clr_sel),
    .req_valid_o(req_valid), .req_opcode_o(req_op), .req_abytes_o(req_ab),
    .req_addr_o(req_addr), .req_dummy_o(req_dummy), .req_len_o(req_len),
    .req_wdata_o(req_wdata), .rsp_done_i(rsp_done), .rsp_err_i(rsp_err),
    .rsp_rdata_i(rsp_rdata), .done_o(done), .ready_o(ready), .busy_o(busy),
    .error_o(error)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one poll; acts as the command engine with one cycle of latency.
  task automatic run_poll(input vec_t v, input bit hold_start);
    int nreq = 0;
    bit fin = 0;
    got_res = 0; got_nrd = 0; got_clr = 8'h00; got_wrdi = 0;
    die_cnt = v.n; oct = v.oct; clr_sel = v.clr;
    start = 1'b1;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
      if (done) begin
        fin = 1; start = 1'b0;
        got_res = ready ? 1 : busy ? 2 : error ? 3 : 0;
        chk((ready + busy + error) == 1, "R9 one flag", {ready, busy, error}, 1);
      end else if (req_valid) begin
        nreq++;
        if (req_op == 8'h65) begin
          chk(got_clr == 0, "R6 read after clear", got_clr, 0);
          chk(req_addr == BASES[got_nrd*32 +: 32], "R3 die order/address R1",
              req_addr, BASES[got_nrd*32 +: 32]);
          if (v.oct)
            chk(req_ab == 4 && req_dummy == 6 && req_len == 2, "R2 octal shape",
                {req_ab, req_dummy, req_len}, {3'd4, 5'd6, 2'd2});
          else
            chk(req_ab == 3 && req_dummy == 0 && req_len == 1, "R1 legacy shape",
                {req_ab, req_dummy, req_len}, {3'd3, 5'd0, 2'd1});
          rsp_rdata = {8'h61, v.st[got_nrd*8 +: 8]};
          got_nrd++;
        end else if (req_op == 8'h04) begin
          chk(got_clr != 0, "R6 disable after clear", got_clr, 1);
          got_wrdi++;
          rsp_rdata = '0;
        end else begin
          got_clr = req_op;
          chk(req_ab == 0 && req_dummy == 0 && req_len == 0, "R7 clear shape",
              {req_ab, req_dummy, req_len}, 0);
          rsp_rdata = '0;
        end
        @(negedge clk);
        chk(!req_valid, "R11 pulse width", req_valid, 0);
        rsp_done = 1'b1;
        rsp_err  = (nreq == int'(v.err_at));
        @(negedge clk);
        rsp_done = 1'b0; rsp_err = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    start = 1'b0;
    if (!fin) chk(0, "R9 no done", 0, 1);
    @(negedge clk);
    chk(!done && !ready && !busy && !error, "R9 flags one cycle",
        {done, ready, busy, error}, 0);
  endtask

  task automatic check_vec(input vec_t v, input string tag);
    chk(got_res == int'(v.res), tag, got_res, v.res);
    chk(got_nrd == int'(v.nrd), "R3 R4 read count", got_nrd, v.nrd);
    chk(got_clr == v.clr_op, "R6 R7 clear opcode", got_clr, v.clr_op);
    chk(got_wrdi == int'(v.wrdi), "R6 R8 write disable", got_wrdi, v.wrdi);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog R9 actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!done && !ready && !busy && !error && !req_valid, "R9 reset",
        {done, ready, busy, error, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !req_valid, "R9 after reset", {done, req_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = VECS[i].err_at != 0 ? "R8 result" : VECS[i].res == 3 ? "R6 result" :
            VECS[i].res == 2 ? "R4 result" : "R5 result";
      run_poll(VECS[i], 1'b0);
      check_vec(VECS[i], tag);
    end

    // R11: stray done while idle has no effect
    rsp_done = 1'b1; rsp_rdata = 16'h0061;
    @(negedge clk);
    rsp_done = 1'b0;
    chk(!done && !req_valid, "R11 stray done", {done, req_valid}, 0);
    @(negedge clk);
    chk(!done && !req_valid, "R11 stray done later", {done, req_valid}, 0);

    // R10: start held high for the whole poll does not restart it
    run_poll('{3'd3, 1'b0, 1'b0, 32'h00000000, 3'd0, 2'd1, 3'd3, 8'h00, 1'b0}, 1'b1);
    chk(got_nrd == 3, "R10 start ignored", got_nrd, 3);
    chk(got_res == 1, "R10 result", got_res, 1);

    // R11: normal poll after a stray done still correct
    run_poll(VECS[2], 1'b0);
    check_vec(VECS[2], "R11 after stray");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule